// File: doc/BRIEF.md
# Burst Word-Address Sequencer

This block produces the low-order word-address bits for a four-beat burst. When a burst opens, the caller presents the starting low bits together with a load strobe. The sequencer stores that start position and reports it as the first beat. Each later cycle in which the advance input is high moves the output to the next position of the burst. A cycle with advance low keeps the current position.

A static mode input selects one of two beat orders:
- Linear order counts upward from the start position and wraps modulo the burst length.
- Interleaved order is the start position XOR the number of beats taken.

Once every position has been visited, further advances wrap back to the start position. The higher address bits are kept outside this block and are not touched by it.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `burst_lo` is 00.
- R2: In the cycle after `load` is high at a clock edge, `burst_lo` equals the value `start_lo` had at that edge, in either mode.
- R3: A clock edge with `load` low and `advance` low leaves `burst_lo` unchanged, provided `interleave` is steady.
- R4: With `interleave` = 0 (linear), each edge with `advance` high and `load` low sets `burst_lo` to its previous value plus one, modulo 4. For example, a start of 11 gives 11, 00, 01, 10.
- R5: With `interleave` = 1, after k advances since the last load, `burst_lo` equals the start value XOR k (mod 4). From start 10 this gives 10, 11, 00, 01. Bit 0 therefore toggles on every advance.
- R6: After four advances since the last load, `burst_lo` equals the start value again, and the sequence then repeats.
- R7: When `load` and `advance` are both high at the same edge, the load wins and the beat count restarts at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Opens a burst at `start_lo` |
| advance | input | 1 | Steps to the next burst position when high |
| interleave | input | 1 | 1 = interleaved order, 0 = linear order |
| start_lo | input | BEAT_W | Externally supplied low address bits |
| burst_lo | output | BEAT_W | Current burst position |

## Verification
The assertions assume that `interleave` is a strap input and changes only between bursts. Because the output follows the mode combinationally, the hold check (R3) and the order checks (R4, R5) apply only to edges around which the mode is steady. The stimulus follows this assumption. It switches mode only in the same cycle as a load, so every stepping run uses a single order. The wrap check counts advances since the most recent load and requires that one load has occurred. Idle cycles right after reset therefore need no start value.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic              interleave,
  input  logic [BEAT_W-1:0] start_lo,
  output logic [BEAT_W-1:0] burst_lo
);

  logic [BEAT_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (load) begin
      base_q <= start_lo;
      beat_q <= '0;
    end else if (advance) begin
      beat_q <= beat_q + 1'b1;
    end
  end

  assign burst_lo = interleave ? (base_q ^ beat_q) : (base_q + beat_q);

endmodule

// File: rtl/burst_addr_chk.sv
module burst_addr_chk #(
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load,
  input logic              advance,
  input logic              interleave,
  input logic [BEAT_W-1:0] start_lo,
  input logic [BEAT_W-1:0] burst_lo
);

  logic [BEAT_W-1:0] cap_q;
  logic [BEAT_W-1:0] steps_q;
  logic              seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q   <= '0;
      steps_q <= '0;
      seen_q  <= 1'b0;
    end else if (load) begin
      cap_q   <= start_lo;
      steps_q <= '0;
      seen_q  <= 1'b1;
    end else if (advance) begin
      steps_q <= steps_q + 1'b1;
    end
  end

  // R1
  always_comb if (!rst_n) reset_zero_chk: assert (burst_lo == '0);

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> burst_lo == $past(start_lo));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !advance) |=> ($stable(interleave) -> $stable(burst_lo)));

  // R4
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && advance && !interleave) |=> (interleave || burst_lo == $past(burst_lo) + 1'b1));

  // R5
  interleave_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && advance && interleave) |=> (!interleave || burst_lo[0] != $past(burst_lo[0])));

  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && steps_q == '0) |-> burst_lo == cap_q);

  // R7
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && advance) |=> burst_lo == $past(start_lo));

endmodule

bind burst_addr_gen burst_addr_chk #(.BEAT_W(BEAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .advance(advance),
  .interleave(interleave), .start_lo(start_lo), .burst_lo(burst_lo)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic       advance = 1'b0;
  logic       interleave = 1'b0;
  logic [1:0] start_lo = 2'b00;
  logic [1:0] burst_lo;

  int checks = 0;
  int failures = 0;
  int ref_start = 0;
  int ref_beats = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  burst_addr_gen #(.BEAT_W(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .load(load), .advance(advance),
    .interleave(interleave), .start_lo(start_lo), .burst_lo(burst_lo)
  );

  function automatic int expect_val(bit il);
    if (il) return (ref_start ^ ref_beats) & 3;
    return (ref_start + ref_beats) % 4;
  endfunction

  task automatic check(string tag, int exp_v);
    checks++;
    if (int'(burst_lo) != exp_v) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, burst_lo, exp_v);
    end
  endtask

  task automatic step(bit ld, bit adv, bit il, logic [1:0] sv);
    string tag;
    @(negedge clk);
    load = ld; advance = adv; interleave = il; start_lo = sv;
    @(posedge clk);
    if (ld) begin
      ref_start = sv; ref_beats = 0;
      tag = adv ? "R7" : "R2";
    end else if (adv) begin
      ref_beats++;
      if (ref_beats % 4 == 0) tag = "R6";
      else tag = il ? "R5" : "R4";
    end else begin
      tag = "R3";
    end
    #1;
    check(tag, expect_val(il));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1", 0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk) #1 check("R1", 0);
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        step(1'b1, 1'b0, m[0], 2'(s));
        for (int k = 0; k < 6; k++) begin
          step(1'b0, 1'b1, m[0], 2'(s + 1));
          if (k == 1) step(1'b0, 1'b0, m[0], 2'(s + 2));
        end
      end
    end
    step(1'b1, 1'b0, 1'b1, 2'b11);
    step(1'b0, 1'b1, 1'b1, 2'b00);
    step(1'b1, 1'b1, 1'b1, 2'b01);
    step(1'b0, 1'b1, 1'b1, 2'b10);
    step(1'b1, 1'b1, 1'b0, 2'b10);
    step(1'b0, 1'b0, 1'b0, 2'b00);
    step(1'b0, 1'b1, 1'b0, 2'b00);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule